// File: doc/BRIEF.md
# TDM Time-Slot Sequencer with Shadow Table

This block walks through a programmable table of slot descriptors once per TDM frame, in one direction. Each 16-bit descriptor covers a run of 1 to 8 units, where a unit is one bit clock or eight bit clocks (a byte), chosen per descriptor. For the length of its slot, the descriptor drives a channel number onto `slot_chan` and any mix of four strobe lines onto `slot_strobe`. A frame sync pulse sends the sequencer back to the first descriptor of the active table. After the descriptor marked last, the block stays idle until the next sync. Each cycle of `clk` counts as one bit clock.

The routing memory holds four banks of 64 descriptors. The host picks a starting bank. The table occupies that bank and every bank above it, so a higher starting bank gives a smaller table. With shadowing on, the table region splits into two equal halves. One half is active. The host can rewrite the other half while traffic keeps running, then ask for a swap. The swap happens at the next frame sync. The memory is not initialised at reset, so the sequencer does nothing until the host sets the enable input.

Top module: `tsa_sequencer`

## Requirements
- R1: After reset, `slot_active`, `slot_chan`, `slot_strobe`, `swap_pending` and `wr_err` are all 0.
- R2: While `cfg_enable` is 0, `fsync` is ignored and the outputs stay idle. Dropping `cfg_enable` during a frame makes `slot_active` 0 one cycle later.
- R3: A `fsync` sampled high while enabled starts the frame at the first descriptor of the active table in the next cycle. A `fsync` arriving during a frame restarts it from that first descriptor.
- R4: Descriptor bits [2:0] hold count-1 and bit 3 selects byte mode. A slot lasts count cycles in bit mode and 8*count cycles in byte mode.
- R5: During a slot, `slot_active` is 1, `slot_chan` equals descriptor bits [11:8], and `slot_strobe[n]` equals descriptor bit 4+n.
- R6: When the slot of a descriptor with bit 15 set ends, or the slot at the last address of the active table ends, the block goes idle. Idle means `slot_active`, `slot_chan` and `slot_strobe` are 0 until the next sync.
- R7: With shadowing off, the active table covers addresses `cfg_start_bank`*64 through 255.
- R8: With shadowing on, the region from `cfg_start_bank`*64 through 255 splits into a lower and an upper half of equal size. The lower half is active after reset. The half that is not active accepts host writes while enabled.
- R9: A `swap_req` pulse with shadowing on sets `swap_pending`. At the next enabled `fsync`, the other half becomes active and `swap_pending` clears. With shadowing off, `swap_req` is ignored.
- R10: A host write to an active-table address while enabled leaves the memory unchanged and sets the sticky `wr_err`. `wr_err` clears while `cfg_enable` is 0. All other writes are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| cfg_enable | input | 1 | Sequencer enable |
| cfg_start_bank | input | 2 | First bank of this TDM's table |
| cfg_shadow_en | input | 1 | Split the table into active and shadow halves |
| fsync | input | 1 | Frame sync pulse |
| host_wr | input | 1 | Host descriptor write strobe |
| host_addr | input | 8 | Descriptor address for the host write |
| host_wdata | input | 16 | Descriptor data for the host write |
| swap_req | input | 1 | Request a swap to the shadow half |
| swap_pending | output | 1 | Swap requested, not yet done |
| wr_err | output | 1 | Write to the active table was rejected |
| slot_active | output | 1 | A slot is in progress |
| slot_chan | output | 4 | Channel number of the current slot |
| slot_strobe | output | 4 | Strobe lines of the current slot |

## Verification
One frame table covers every count from 1 to 8 in both bit and byte mode, with a distinct channel and strobe pattern for each descriptor. Checking that frame cycle by cycle catches length errors, wrong field slicing and a wrong strobe bit order. A second table of 64 single-bit descriptors with no last mark, placed at a high starting bank, separates a stop on the last flag from a stop at the end of the table, and also shows where the table sits in memory. Shadow tables with different contents in each half show which half is live before and after a swap. Writes aimed at the active half, at the shadow half and outside the table, each followed by a replayed frame, show which writes are stored and which are blocked.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
   localparam int ENTRY_W  = 16;
   localparam int RUN_LSB  = 0;
   localparam int RUN_W    = 3;
   localparam int BYTE_BIT = 3;
   localparam int STB_LSB  = 4;
   localparam int NUM_STB  = 4;
   localparam int CHAN_LSB = STB_LSB + NUM_STB;
   localparam int CHAN_W   = 4;
   localparam int LAST_BIT = ENTRY_W - 1;
   localparam int UNIT_SH  = 3;
   localparam int LEN_W    = RUN_W + UNIT_SH + 1;

   typedef logic [ENTRY_W-1:0] entry_t;

   function automatic logic [LEN_W-1:0] slot_cycles(input entry_t e);
      logic [LEN_W-1:0] n;
      n = LEN_W'(e[RUN_LSB +: RUN_W]) + LEN_W'(1);
      return e[BYTE_BIT] ? (n << UNIT_SH) : n;
   endfunction
endpackage

// File: rtl/tsa_route_mem.sv
module tsa_route_mem
   import tsa_pkg::*;
#(
   parameter int NUM_BANKS  = 4,
   parameter int BANK_DEPTH = 64,
   localparam int DEPTH     = NUM_BANKS * BANK_DEPTH,
   localparam int ADDR_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [ADDR_W-1:0] act_lo,
   input  logic [ADDR_W-1:0] act_hi,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  entry_t            host_wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output entry_t            rd_data,
   output logic              wr_err
);
   entry_t store [DEPTH];
   logic   in_active;

   assign in_active = enable && (host_addr >= act_lo) && (host_addr <= act_hi);

   always_ff @(posedge clk) begin
      if (host_wr && !in_active) begin
         store[host_addr] <= host_wdata;
      end
   end

   assign rd_data = store[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_err <= 1'b0;
      end else if (!enable) begin
         wr_err <= 1'b0;
      end else if (host_wr && in_active) begin
         wr_err <= 1'b1;
      end
   end

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_err) |-> $past(host_wr));                              // R10
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err && enable |=> wr_err);                                   // R10
endmodule

// File: rtl/tsa_table_ctrl.sv
module tsa_table_ctrl #(
   parameter int NUM_BANKS      = 4,
   parameter int BANK_DEPTH     = 64,
   parameter bit SHADOW_SUPPORT = 1'b1,
   localparam int DEPTH         = NUM_BANKS * BANK_DEPTH,
   localparam int ADDR_W        = $clog2(DEPTH),
   localparam int BANK_W        = $clog2(NUM_BANKS),
   localparam int SZ_W          = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              fsync,
   input  logic [BANK_W-1:0] start_bank,
   input  logic              shadow_en,
   input  logic              swap_req,
   output logic [ADDR_W-1:0] act_lo,
   output logic [ADDR_W-1:0] act_hi,
   output logic [ADDR_W-1:0] load_base,
   output logic              swap_pending
);
   logic [SZ_W-1:0] region_lo, region_n, half_n, cur_lo, cur_n, oth_lo, cur_end;
   logic            act_half, eff_half, swap_now;

   assign region_lo = SZ_W'(start_bank) * SZ_W'(BANK_DEPTH);
   assign region_n  = (SZ_W'(NUM_BANKS) - SZ_W'(start_bank)) * SZ_W'(BANK_DEPTH);
   assign half_n    = region_n >> 1;
   assign eff_half  = shadow_en && act_half;
   assign cur_lo    = region_lo + (eff_half ? half_n : '0);
   assign oth_lo    = region_lo + (eff_half ? '0 : half_n);
   assign cur_n     = shadow_en ? half_n : region_n;
   assign cur_end   = cur_lo + cur_n - SZ_W'(1);
   assign swap_now  = enable && fsync && shadow_en && swap_pending;

   assign act_lo    = cur_lo[ADDR_W-1:0];
   assign act_hi    = cur_end[ADDR_W-1:0];
   assign load_base = swap_now ? oth_lo[ADDR_W-1:0] : cur_lo[ADDR_W-1:0];

   generate
      if (SHADOW_SUPPORT) begin : g_shadow
         logic req_ok;
         assign req_ok = swap_req && shadow_en;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_half     <= 1'b0;
               swap_pending <= 1'b0;
            end else begin
               if (swap_now) begin
                  act_half <= ~act_half;
               end
               swap_pending <= swap_now ? req_ok : (swap_pending || req_ok);
            end
         end

         AST_SWAP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            swap_now && !swap_req |=> !swap_pending);                 // R9
         AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(enable && fsync) |=> $stable(act_half));                // R9
         AST_NO_SHADOW_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            !shadow_en && !swap_pending |=> !swap_pending);           // R9
      end else begin : g_flat
         assign act_half     = 1'b0;
         assign swap_pending = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tsa_slot_engine.sv
module tsa_slot_engine
   import tsa_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               fsync,
   input  logic [ADDR_W-1:0]  load_base,
   input  logic [ADDR_W-1:0]  tbl_hi,
   input  entry_t             entry,
   output logic [ADDR_W-1:0]  rd_ptr,
   output logic               slot_active,
   output logic [CHAN_W-1:0]  slot_chan,
   output logic [NUM_STB-1:0] slot_strobe
);
   logic             running;
   logic [LEN_W-1:0] cnt, len;
   logic             slot_end, stop_here;
   logic [2:0]       unused_rsvd;

   assign unused_rsvd = entry[LAST_BIT-1 -: 3];
   assign len         = slot_cycles(entry);
   assign slot_end    = running && (cnt == len - LEN_W'(1));
   assign stop_here   = entry[LAST_BIT] || (rd_ptr == tbl_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         rd_ptr  <= '0;
         cnt     <= '0;
      end else if (!enable) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (fsync) begin
         running <= 1'b1;
         rd_ptr  <= load_base;
         cnt     <= '0;
      end else if (slot_end) begin
         cnt <= '0;
         if (stop_here) begin
            running <= 1'b0;
         end else begin
            rd_ptr <= rd_ptr + ADDR_W'(1);
         end
      end else if (running) begin
         cnt <= cnt + LEN_W'(1);
      end
   end

   assign slot_active = running;
   assign slot_chan   = running ? entry[CHAN_LSB +: CHAN_W] : '0;
   assign slot_strobe = running ? entry[STB_LSB +: NUM_STB] : '0;

   AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !slot_active);                                      // R2
   AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      enable && fsync |=> running && rd_ptr == $past(load_base));     // R3
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> cnt < len);                                         // R4
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      running && enable && !fsync && !slot_end |=> cnt == $past(cnt) + LEN_W'(1)); // R4
   AST_LAST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      slot_end && stop_here && enable && !fsync |=> !slot_active);    // R6
endmodule

// File: rtl/tsa_sequencer.sv
module tsa_sequencer
   import tsa_pkg::*;
#(
   parameter int NUM_BANKS      = 4,
   parameter int BANK_DEPTH     = 64,
   parameter bit SHADOW_SUPPORT = 1'b1,
   localparam int DEPTH         = NUM_BANKS * BANK_DEPTH,
   localparam int ADDR_W        = $clog2(DEPTH),
   localparam int BANK_W        = $clog2(NUM_BANKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_enable,
   input  logic [BANK_W-1:0]  cfg_start_bank,
   input  logic               cfg_shadow_en,
   input  logic               fsync,
   input  logic               host_wr,
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic [ENTRY_W-1:0] host_wdata,
   input  logic               swap_req,
   output logic               swap_pending,
   output logic               wr_err,
   output logic               slot_active,
   output logic [CHAN_W-1:0]  slot_chan,
   output logic [NUM_STB-1:0] slot_strobe
);
   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two of at least 2");
      end
      if (BANK_DEPTH < 2 || (BANK_DEPTH & (BANK_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("BANK_DEPTH must be a power of two of at least 2");
      end
      if (CHAN_LSB + CHAN_W > LAST_BIT - 3) begin : g_bad_layout
         $error("descriptor fields overlap the reserved or last bits");
      end
   endgenerate

   logic [ADDR_W-1:0] act_lo, act_hi, load_base, rd_ptr;
   entry_t            rd_data;

   tsa_table_ctrl #(
      .NUM_BANKS     (NUM_BANKS),
      .BANK_DEPTH    (BANK_DEPTH),
      .SHADOW_SUPPORT(SHADOW_SUPPORT)
   ) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (cfg_enable),
      .fsync       (fsync),
      .start_bank  (cfg_start_bank),
      .shadow_en   (cfg_shadow_en),
      .swap_req    (swap_req),
      .act_lo      (act_lo),
      .act_hi      (act_hi),
      .load_base   (load_base),
      .swap_pending(swap_pending)
   );

   tsa_route_mem #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_DEPTH(BANK_DEPTH)
   ) mem_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (cfg_enable),
      .act_lo    (act_lo),
      .act_hi    (act_hi),
      .host_wr   (host_wr),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .rd_addr   (rd_ptr),
      .rd_data   (rd_data),
      .wr_err    (wr_err)
   );

   tsa_slot_engine #(
      .ADDR_W(ADDR_W)
   ) eng_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (cfg_enable),
      .fsync      (fsync),
      .load_base  (load_base),
      .tbl_hi     (act_hi),
      .entry      (rd_data),
      .rd_ptr     (rd_ptr),
      .slot_active(slot_active),
      .slot_chan  (slot_chan),
      .slot_strobe(slot_strobe)
   );
endmodule

// File: tb/tsa_sequencer_tb_top.sv
module tsa_sequencer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b0;
   logic [1:0]  cfg_start_bank = 2'd0;
   logic        cfg_shadow_en = 1'b0;
   logic        fsync = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_addr = 8'd0;
   logic [15:0] host_wdata = 16'd0;
   logic        swap_req = 1'b0;
   logic        swap_pending, wr_err, slot_active;
   logic [3:0]  slot_chan, slot_strobe;

   int checks = 0;
   int failures = 0;
   logic [15:0] mirror [256];

   always #4 clk = ~clk;

   tsa_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
      .cfg_start_bank(cfg_start_bank), .cfg_shadow_en(cfg_shadow_en),
      .fsync(fsync), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .swap_req(swap_req),
      .swap_pending(swap_pending), .wr_err(wr_err),
      .slot_active(slot_active), .slot_chan(slot_chan), .slot_strobe(slot_strobe)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int len_of(input logic [15:0] e);
      return (int'(e[2:0]) + 1) * (e[3] ? 8 : 1);
   endfunction

   task automatic host_write(input int a, input logic [15:0] d, input bit accepted);
      @(negedge clk);
      host_wr = 1'b1; host_addr = 8'(a); host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
      if (accepted) mirror[a] = d;
   endtask

   task automatic pulse_sync();
      @(negedge clk); fsync = 1'b1;
      @(negedge clk); fsync = 1'b0;
   endtask

   task automatic run_frame(input int base, input int hi, input string tag);
      int idx, rem, idle, mism, bad_cyc, cyc;
      bit act;
      logic [3:0] ec, es;
      @(negedge clk); fsync = 1'b1;
      @(negedge clk); fsync = 1'b0;
      idx = base; rem = len_of(mirror[idx]); act = 1'b1;
      idle = 0; mism = 0; bad_cyc = 0; cyc = 0;
      while (idle < 4) begin
         ec = act ? mirror[idx][11:8] : 4'd0;
         es = act ? mirror[idx][7:4]  : 4'd0;
         if (slot_active !== act || slot_chan !== ec || slot_strobe !== es) begin
            if (mism == 0) begin
               bad_cyc = cyc;
               $display("  mismatch at cycle %0d: active=%0d chan=%0d strobe=%0d exp %0d %0d %0d",
                        cyc, slot_active, slot_chan, slot_strobe, act, ec, es);
            end
            mism++;
         end
         if (act) begin
            rem--;
            if (rem == 0) begin
               if (mirror[idx][15] || idx == hi) act = 1'b0;
               else begin
                  idx++;
                  rem = len_of(mirror[idx]);
               end
            end
         end else begin
            idle++;
         end
         cyc++;
         @(negedge clk);
      end
      chk(mism == 0, tag, $sformatf("frame mismatching cycles (first %0d)", bad_cyc), mism, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mirror[i] = 16'd0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(slot_active == 0, "R1", "slot_active", slot_active, 0);
      chk(slot_chan == 0 && slot_strobe == 0, "R1", "chan|strobe", {slot_chan, slot_strobe}, 0);
      chk(swap_pending == 0, "R1", "swap_pending", swap_pending, 0);
      chk(wr_err == 0, "R1", "wr_err", wr_err, 0);

      // Sweep table: every count in bit and byte mode
      for (int i = 0; i < 16; i++)
         host_write(i, {(i == 15), 3'b000, 4'(i), 4'(i ^ 5), (i >= 8), 3'(i % 8)}, 1'b1);
      chk(wr_err == 0, "R10", "write while disabled err", wr_err, 0);

      // R2: sync ignored while disabled
      pulse_sync();
      begin
         int seen = 0;
         for (int k = 0; k < 6; k++) begin
            if (slot_active) seen++;
            @(negedge clk);
         end
         chk(seen == 0, "R2", "active cycles while disabled", seen, 0);
      end

      cfg_enable = 1'b1;
      run_frame(0, 255, "R4 R5 R6");

      // R3: restart in mid frame
      pulse_sync();
      repeat (20) @(negedge clk);
      run_frame(0, 255, "R3");

      // R2: disable in mid frame
      pulse_sync();
      repeat (5) @(negedge clk);
      cfg_enable = 1'b0;
      @(negedge clk);
      chk(slot_active == 0 && slot_chan == 0, "R2", "active after disable", slot_active, 0);
      cfg_enable = 1'b1;

      // R10: rejected write to the active table
      host_write(5, 16'h0F7F, 1'b0);
      chk(wr_err == 1, "R10", "wr_err after active write", wr_err, 1);
      run_frame(0, 255, "R10");
      chk(wr_err == 1, "R10", "wr_err sticky", wr_err, 1);
      @(negedge clk); cfg_enable = 1'b0;
      @(negedge clk);
      chk(wr_err == 0, "R10", "wr_err cleared by disable", wr_err, 0);

      // R7: table at start bank 3, no last marks
      for (int i = 0; i < 64; i++)
         host_write(192 + i, {4'b0000, 4'(i), 4'(~i), 4'b0000}, 1'b1);
      cfg_start_bank = 2'd3;
      cfg_enable = 1'b1;
      host_write(0, 16'hFFFF, 1'b1);
      chk(wr_err == 0, "R7", "write below table err", wr_err, 0);
      run_frame(192, 255, "R6 R7");
      host_write(200, 16'h1234, 1'b0);
      chk(wr_err == 1, "R7", "write inside table err", wr_err, 1);
      run_frame(192, 255, "R7");

      // R9: swap ignored without shadow
      @(negedge clk); swap_req = 1'b1;
      @(negedge clk); swap_req = 1'b0;
      chk(swap_pending == 0, "R9", "pending without shadow", swap_pending, 0);

      // R8: shadow halves at start bank 2
      cfg_enable = 1'b0;
      cfg_start_bank = 2'd2;
      cfg_shadow_en = 1'b1;
      host_write(128, 16'h0351, 1'b1);
      host_write(129, 16'h07A8, 1'b1);
      host_write(130, 16'h8C32, 1'b1);
      host_write(131, 16'h0EF0, 1'b1);
      host_write(192, 16'h0290, 1'b1);
      host_write(193, 16'h0461, 1'b1);
      host_write(194, 16'h89FA, 1'b1);
      cfg_enable = 1'b1;
      run_frame(128, 191, "R8");
      host_write(193, 16'h0B5C, 1'b1);
      chk(wr_err == 0, "R8", "shadow write err", wr_err, 0);

      @(negedge clk); swap_req = 1'b1;
      @(negedge clk); swap_req = 1'b0;
      chk(swap_pending == 1, "R9", "pending after request", swap_pending, 1);
      repeat (3) @(negedge clk);
      chk(swap_pending == 1, "R9", "pending held until sync", swap_pending, 1);
      run_frame(192, 255, "R8 R9");
      chk(swap_pending == 0, "R9", "pending after swap", swap_pending, 0);
      host_write(130, 16'h8111, 1'b1);
      chk(wr_err == 0, "R10", "write to old half err", wr_err, 0);
      host_write(200, 16'h8222, 1'b0);
      chk(wr_err == 1, "R10", "write to new active half err", wr_err, 1);
      run_frame(192, 255, "R9");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule